// File: doc/BRIEF.md
# Chainable PWM Time-Base Counter

This block holds a row of up-counting PWM time-base counters that all advance on one shared clock enable (`tick`). Each counter climbs from zero to its own programmed period and then returns to zero. The span between two ticks is one count slot. In the first clock of a slot whose value is zero, a channel raises a one-clock zero pulse. That pulse is also the channel's sync output. A similar pulse marks a slot whose value equals the period. Downstream trigger logic uses both pulses.

The channels form a chain. Channel 0 takes its sync input from the `ext_sync` pin. Every later channel takes the zero pulse of the channel before it. A sync pulse is accepted only when that channel's sync enable is set. The pulse is then held until the tick that ends the current slot, and on that tick the counter takes its phase value instead of stepping. The load can only replace the step that follows the master's zero slot. A slave meant to run in line with its master therefore needs a phase of 1. With a phase of 0 the slave repeats zero and gives a second zero pulse.

Configuration goes through one write port while `run` is low. Writes made while `run` is high are dropped. While stopped, each counter shows its programmed start value. Once `run` rises, all channels count together from their start values.

Top module: `pwm_timebase_chain`

## Requirements
- R1: After reset every counter reads 0, both pulse outputs are low, every period is 0xFFFF, every phase and start value is 0, and every sync enable is off. While `run` is low each counter shows its start value and holds it, and no pulse is raised.
- R2: A counter changes only on a clock where `run` and `tick` are both high. It holds through every running clock with `tick` low.
- R3: On each tick a counter that is below its period steps up by one. A counter that equals its period goes to 0 on the tick.
- R4: `zero_o[i]` is high for exactly the first clock of each slot in which channel i reads 0. A slot begins on the clock after a running tick, or on the first clock with `run` high. This pulse is channel i's sync output.
- R5: `prd_o[i]` is high for the first clock of a slot in which channel i equals its period. It stays low when that value came from a phase load.
- R6: Channel 0 is synced by `ext_sync` and channel i by `zero_o[i-1]`. With the sync enable set, a sync pulse seen on any running clock is held until the next tick. That tick loads the phase value instead of stepping. Pending pulses are dropped while `run` is low.
- R7: A phase load that sets the counter to 0 raises a zero pulse at the start of the following slot, just as a wrap does.
- R8: If master and slave both start at 0 and the slave phase is 0, the slave reads 0 for two slots and gives two zero pulses in the first five slots. With a slave phase of 1, the slave equals its master in every slot and gives one zero pulse in those five slots.
- R9: With its sync enable clear, a channel ignores sync pulses entirely and keeps counting.
- R10: A write is taken when `cfg_we` is high and `run` is low. It goes to channel `cfg_ch`, and `cfg_fld` selects the field: 0 = period, 1 = phase, 2 = start value, 3 = sync enable (`cfg_data` bit 0). Writes made while `run` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Global start; low holds every counter at its start value |
| tick | input | 1 | Shared count enable |
| ext_sync | input | 1 | Sync input of channel 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Target channel of a write |
| cfg_fld | input | 2 | Field selector (0 period, 1 phase, 2 start, 3 sync enable) |
| cfg_data | input | W | Write data |
| cnt_o | output | N_CH*W | Counter values, channel i at bits [i*W +: W] |
| zero_o | output | N_CH | Zero-slot pulses, also the sync outputs |
| prd_o | output | N_CH | Period-slot pulses |

## Verification
A phase load and a slot event can land in the same cycle. The sync arrives in the very slot in which the slave already reads zero, or already reads its period, so the load decides what the next slot shows. The bench provokes this in three ways. It starts master and slave together with phase 0 and then with phase 1. It sends an external sync on a clock between slow ticks, with the phase equal to the period. Each outcome is judged twice: against a clock-by-clock behavioural model and against hand-worked slot values, zero-pulse counts and period-pulse counts.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

   // field codes used by the configuration port
   typedef enum logic [1:0] {
      FLD_PERIOD  = 2'd0,
      FLD_PHASE   = 2'd1,
      FLD_START   = 2'd2,
      FLD_SYNC_EN = 2'd3
   } cfg_fld_e;

   // per-channel slot event pair
   typedef struct packed {
      logic zero;
      logic prd;
   } slot_evt_t;

endpackage

// File: rtl/pwmtb_cfg.sv
module pwmtb_cfg
   import pwmtb_pkg::*;
#(
   parameter int          W       = 16,
   parameter int          CHW     = 2,
   parameter int          CH_ID   = 0,
   parameter int unsigned PRD_RST = 65535
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           we,
   input  logic [CHW-1:0] ch,
   input  logic [1:0]     fld,
   input  logic [W-1:0]   data,
   output logic [W-1:0]   period,
   output logic [W-1:0]   phase,
   output logic [W-1:0]   start_val,
   output logic           sync_en
);

   localparam logic [CHW-1:0] MY_ID   = CHW'(CH_ID);
   localparam logic [W-1:0]   PRD_INI = W'(PRD_RST);

   logic     hit;
   cfg_fld_e sel_fld;

   // writes land only while the time base is stopped
   assign hit     = we & ~run & (ch == MY_ID);
   assign sel_fld = cfg_fld_e'(fld);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period    <= PRD_INI;
         phase     <= '0;
         start_val <= '0;
         sync_en   <= 1'b0;
      end else if (hit) begin
         unique case (sel_fld)
            FLD_PERIOD:  period    <= data;
            FLD_PHASE:   phase     <= data;
            FLD_START:   start_val <= data;
            FLD_SYNC_EN: sync_en   <= data[0];
         endcase
      end
   end

endmodule

// File: rtl/pwmtb_sync_gate.sv
module pwmtb_sync_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic sync_en,
   input  logic sync_in,
   output logic load
);

   logic pend_q;

   // a pulse between ticks waits for the tick that closes the slot
   assign load = run & tick & sync_en & (sync_in | pend_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (!run || !sync_en) begin
         pend_q <= 1'b0;
      end else if (tick) begin
         pend_q <= 1'b0;
      end else if (sync_in) begin
         pend_q <= 1'b1;
      end
   end

endmodule

// File: rtl/pwmtb_core.sv
module pwmtb_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] phase,
   input  logic [W-1:0] period,
   input  logic [W-1:0] start_val,
   output logic [W-1:0] cnt,
   output logic         fresh,
   output logic         by_load
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] step;
   logic [W-1:0] cnt_d;
   logic         at_prd;

   assign at_prd = (cnt_q == period);
   assign step   = at_prd ? '0 : cnt_q + 1'b1;
   assign cnt_d  = load ? phase : step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fresh   <= 1'b1;
         by_load <= 1'b0;
      end else if (!run) begin
         cnt_q   <= start_val;
         fresh   <= 1'b1;
         by_load <= 1'b0;
      end else if (tick) begin
         cnt_q   <= cnt_d;
         fresh   <= 1'b1;
         by_load <= load;
      end else begin
         fresh   <= 1'b0;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/pwmtb_chan.sv
module pwmtb_chan
   import pwmtb_pkg::*;
#(
   parameter int          W       = 16,
   parameter int          CHW     = 2,
   parameter int          CH_ID   = 0,
   parameter int unsigned PRD_RST = 65535
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           tick,
   input  logic           sync_in,
   input  logic           cfg_we,
   input  logic [CHW-1:0] cfg_ch,
   input  logic [1:0]     cfg_fld,
   input  logic [W-1:0]   cfg_data,
   output logic [W-1:0]   cnt,
   output slot_evt_t      evt
);

   logic [W-1:0] period, phase, start_val;
   logic         sync_en, load, fresh, by_load;

   pwmtb_cfg #(
      .W(W), .CHW(CHW), .CH_ID(CH_ID), .PRD_RST(PRD_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .run(run), .we(cfg_we), .ch(cfg_ch),
      .fld(cfg_fld), .data(cfg_data), .period(period), .phase(phase),
      .start_val(start_val), .sync_en(sync_en)
   );

   pwmtb_sync_gate u_gate (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .sync_en(sync_en), .sync_in(sync_in), .load(load)
   );

   pwmtb_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(load),
      .phase(phase), .period(period), .start_val(start_val),
      .cnt(cnt), .fresh(fresh), .by_load(by_load)
   );

   // events belong to the first clock of a slot; loads never mark the period
   always_comb begin
      evt.zero = run & fresh & (cnt == '0);
      evt.prd  = run & fresh & (cnt == period) & ~by_load;
   end

endmodule

// File: rtl/pwm_timebase_chain.sv
module pwm_timebase_chain
   import pwmtb_pkg::*;
#(
   parameter int          W       = 16,
   parameter int          N_CH    = 3,
   parameter int unsigned PRD_RST = 65535,
   localparam int         CHW     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            tick,
   input  logic            ext_sync,
   input  logic            cfg_we,
   input  logic [CHW-1:0]  cfg_ch,
   input  logic [1:0]      cfg_fld,
   input  logic [W-1:0]    cfg_data,
   output logic [N_CH*W-1:0] cnt_o,
   output logic [N_CH-1:0] zero_o,
   output logic [N_CH-1:0] prd_o
);

   // elaboration checks
   if (W < 2 || W > 32) begin : g_bad_width
      $error("pwm_timebase_chain: W must lie in 2..32");
   end
   if (N_CH < 1 || N_CH > 64) begin : g_bad_count
      $error("pwm_timebase_chain: N_CH must lie in 1..64");
   end
   if (W < 32 && PRD_RST > ((64'd1 << W) - 64'd1)) begin : g_bad_prd
      $error("pwm_timebase_chain: PRD_RST does not fit in W bits");
   end

   logic [N_CH-1:0] sync_w;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      slot_evt_t    evt;
      logic [W-1:0] cnt;

      if (g == 0) begin : g_head
         assign sync_w[g] = ext_sync;
      end else begin : g_link
         assign sync_w[g] = zero_o[g-1];
      end

      pwmtb_chan #(
         .W(W), .CHW(CHW), .CH_ID(g), .PRD_RST(PRD_RST)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
         .sync_in(sync_w[g]), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
         .cfg_fld(cfg_fld), .cfg_data(cfg_data), .cnt(cnt), .evt(evt)
      );

      assign cnt_o[g*W +: W] = cnt;
      assign zero_o[g]       = evt.zero;
      assign prd_o[g]        = evt.prd;
   end

endmodule

// File: rtl/pwmtb_chk.sv
module pwmtb_chk #(
   parameter int W    = 16,
   parameter int N_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              tick,
   input logic              cfg_we,
   input logic [N_CH*W-1:0] cnt_o,
   input logic [N_CH-1:0]   zero_o
);

   // R2
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_o));

   // R1
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cfg_we && $past(!run) && $past(!cfg_we)) |=> $stable(cnt_o));

   for (genvar g = 0; g < N_CH; g++) begin : g_chk
      // R4
      zero_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (zero_o[g] && !tick) |=> !zero_o[g]);

      // R4
      zero_slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(zero_o[g]) |-> ($past(tick) || !$past(run)));
   end

endmodule

bind pwm_timebase_chain pwmtb_chk #(.W(W), .N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cfg_we(cfg_we),
   .cnt_o(cnt_o), .zero_o(zero_o)
);

// File: tb/tb_pwm_timebase_chain.sv
module tb_pwm_timebase_chain;

   localparam int W   = 16;
   localparam int N   = 3;
   localparam int CHW = 2;
   localparam int PRD0 = 65535;

   logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, tick = 1'b0, ext_sync = 1'b0;
   logic cfg_we = 1'b0;
   logic [CHW-1:0] cfg_ch = '0;
   logic [1:0] cfg_fld = '0;
   logic [W-1:0] cfg_data = '0;
   logic [N*W-1:0] cnt_o;
   logic [N-1:0] zero_o, prd_o;

   always #10 clk = ~clk;   // 50 MHz

   pwm_timebase_chain #(.W(W), .N_CH(N), .PRD_RST(PRD0)) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .ext_sync(ext_sync),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld), .cfg_data(cfg_data),
      .cnt_o(cnt_o), .zero_o(zero_o), .prd_o(prd_o)
   );

   int total = 0, fails = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // behavioural reference model
   int m_prd[N], m_ph[N], m_st[N], m_cnt[N];
   bit m_sen[N], m_fresh[N], m_byl[N], m_pend[N];
   bit zp[N];

   function automatic bit ez(int i);
      return run && m_fresh[i] && (m_cnt[i] == 0);
   endfunction

   function automatic bit ep(int i);
      return run && m_fresh[i] && (m_cnt[i] == m_prd[i]) && !m_byl[i];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_prd[i] = PRD0; m_ph[i] = 0; m_st[i] = 0; m_cnt[i] = 0;
            m_sen[i] = 0; m_fresh[i] = 1; m_byl[i] = 0; m_pend[i] = 0;
         end
      end else begin
         for (int i = 0; i < N; i++) zp[i] = ez(i);
         for (int i = 0; i < N; i++) begin
            bit sin, ld;
            sin = (i == 0) ? ext_sync : zp[i-1];
            ld  = run && tick && m_sen[i] && (sin || m_pend[i]);
            if (!run || !m_sen[i]) m_pend[i] = 0;
            else if (tick)         m_pend[i] = 0;
            else if (sin)          m_pend[i] = 1;
            if (!run) begin
               m_cnt[i] = m_st[i]; m_fresh[i] = 1; m_byl[i] = 0;
            end else if (tick) begin
               if (ld) m_cnt[i] = m_ph[i];
               else if (m_cnt[i] == m_prd[i]) m_cnt[i] = 0;
               else m_cnt[i] = (m_cnt[i] + 1) % 65536;
               m_fresh[i] = 1; m_byl[i] = ld;
            end else begin
               m_fresh[i] = 0;
            end
            if (cfg_we && !run && cfg_ch == i) begin
               case (cfg_fld)
                  2'd0: m_prd[i] = cfg_data;
                  2'd1: m_ph[i]  = cfg_data;
                  2'd2: m_st[i]  = cfg_data;
                  default: m_sen[i] = cfg_data[0];
               endcase
            end
         end
      end
   end

   // cycle compare, 2 ns before each rising edge
   always @(negedge clk) begin
      #8;
      if (rst_n) begin
         for (int i = 0; i < N; i++) begin
            chk($sformatf("R3 ch%0d count", i), cnt_o[i*W +: W], m_cnt[i]);
            chk($sformatf("R4 ch%0d zero", i), zero_o[i], ez(i));
            chk($sformatf("R5 ch%0d period", i), prd_o[i], ep(i));
         end
      end
   end

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic wr(input int ch, input int fld, input int val);
      nxt();
      cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_fld = 2'(fld); cfg_data = W'(val);
      nxt();
      cfg_we = 1'b0;
   endtask

   function automatic int cv(int i);
      return int'(cnt_o[i*W +: W]);
   endfunction

   initial begin
      #(20 * 50000);
      fails++; total++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int z0, z1, p2;
      logic [N*W-1:0] snap;
      repeat (3) nxt();
      rst_n = 1'b1;
      #8;
      chk("R1 reset counters", cnt_o, 0);
      chk("R1 reset zero pulses", zero_o, 0);
      chk("R1 reset period pulses", prd_o, 0);

      // R10 configuration while stopped
      wr(0, 0, 4); wr(1, 0, 4); wr(2, 0, 4);
      wr(1, 3, 1); wr(1, 1, 0); wr(2, 2, 2);
      nxt(); #8;
      chk("R1 R10 stopped shows start value ch2", cv(2), 2);

      // R8 phase 0: slave repeats zero
      nxt(); run = 1'b1; tick = 1'b1;
      z0 = 0; z1 = 0;
      for (int k = 0; k < 5; k++) begin
         #8;
         z0 += zero_o[0]; z1 += zero_o[1];
         if (k == 1) begin
            chk("R8 slave pulled back to 0", cv(1), 0);
            chk("R7 zero pulse after load to 0", zero_o[1], 1);
         end
         if (k == 4) chk("R9 ch2 ignores sync", cv(2), 1);
         nxt();
      end
      chk("R8 master zero pulses", z0, 1);
      chk("R8 slave zero pulses with phase 0", z1, 2);

      // R10 write while running is ignored
      wr(2, 0, 1);
      p2 = 0;
      for (int k = 0; k < 10; k++) begin
         #8; p2 += prd_o[2]; nxt();
      end
      chk("R10 running write dropped (ch2 period pulses)", p2, 2);

      // R2 hold with tick low
      tick = 1'b0;
      #8; snap = cnt_o;
      repeat (3) nxt();
      #8;
      chk("R2 counters hold without tick", cnt_o, snap);
      nxt();

      // R8 phase 1: aligned
      run = 1'b0;
      nxt();
      wr(1, 1, 1);
      nxt(); run = 1'b1; tick = 1'b1;
      z1 = 0;
      for (int k = 0; k < 12; k++) begin
         #8;
         if (k < 5) z1 += zero_o[1];
         if (k == 1 || k == 6 || k == 11)
            chk($sformatf("R8 slave aligned slot %0d", k), cv(1), cv(0));
         nxt();
      end
      chk("R8 slave zero pulses with phase 1", z1, 1);

      // R6 R5 pending sync with slow tick, phase equal to period
      run = 1'b0; tick = 1'b0;
      nxt();
      wr(0, 3, 1); wr(0, 1, 4);
      nxt(); run = 1'b1;
      for (int c = 0; c < 12; c++) begin
         tick     = (c % 3 == 2);
         ext_sync = (c == 4);
         #8;
         if (c == 5) chk("R6 pending sync keeps count before tick", cv(0), 1);
         if (c == 6) begin
            chk("R6 phase loaded on tick", cv(0), 4);
            chk("R5 no period pulse after load", prd_o[0], 0);
         end
         if (c == 9)  chk("R3 R4 wrap gives zero pulse", zero_o[0], 1);
         if (c == 10) chk("R4 zero pulse lasts one clock", zero_o[0], 0);
         nxt();
      end
      ext_sync = 1'b0; tick = 1'b0; run = 1'b0;
      nxt(); nxt();
      finish_run();
   end

endmodule